// File: doc/BRIEF.md
# Multi-Block Fetch Address Cache

This block sits at the front of an instruction fetch unit. Each cycle it can take one fetch address and look it up in a tagged, direct-mapped table. A hit returns a small two-level tree of next-block addresses. The first level holds a taken and a fall-through address for the branch that ends the current block. The second level holds four addresses for the branch that ends the block reached next. Two direction bits from an external multiple-branch predictor pick one path through that tree. The fetch unit therefore gets the start addresses of up to three consecutive basic blocks from a single access.

A write port installs or replaces a whole entry once branch outcomes and targets are resolved. The result of a lookup is registered and appears on the cycle after the request. Unused block slots are filled with sequential fall-through addresses, so the consumer can always read three addresses and use the count to tell how many blocks the table vouched for.

Top module: `fetch_addr_cache`

## Requirements
- R1: After reset, `rs_valid` is 0, `rs_count` is 0 and every table entry is invalid, so any lookup before the first write misses.
- R2: A lookup presented with `lk_valid` high produces `rs_valid` high on the next cycle, with `rs_blk0` equal to the looked-up address. A cycle without a lookup gives `rs_valid` low on the next cycle.
- R3: On a miss, `rs_hit` is 0, `rs_count` is 1, `rs_blk1` is the address plus 4 and `rs_blk2` is the address plus 8.
- R4: The table index is address bits [7:2] (64 entries) and the tag is bits [31:8]. A lookup whose index matches a valid entry but whose tag differs is a miss.
- R5: On a hit whose primary-valid flag is clear, `rs_hit` is 1, `rs_count` is 1 and the block slots follow the sequential rule of R3.
- R6: For branch type 0 (conditional) or 2 (return), `lk_dir[0]` = 1 selects the primary taken address and 0 selects the primary not-taken address as `rs_blk1`.
- R7: Branch type 1 (unconditional) always takes the taken side and type 3 (no branch) always takes the not-taken side, whatever the predictor bit says.
- R8: The side chosen at the first level supplies the second-level valid flag and type. `lk_dir[1]` then selects `rs_blk2` among that side's two second-level addresses, under the same type rules as R6 and R7. When valid, `rs_count` is 3.
- R9: If the selected second-level valid flag is clear, `rs_count` is 2 and `rs_blk2` is `rs_blk1` plus 4.
- R10: A write replaces a whole entry in one cycle. A lookup to the same entry in that cycle returns the old contents, and a lookup on the following cycle returns the new ones.
- R11: Writes to one index leave entries at other indices unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Fetch address to look up |
| lk_dir | input | 2 | Predicted directions; bit 0 first branch, bit 1 second branch, 1 = taken |
| wr_en | input | 1 | Install or replace an entry |
| wr_addr | input | 32 | Fetch address the entry belongs to |
| wr_pvalid | input | 1 | Primary branch present |
| wr_ptype | input | 2 | Primary branch type |
| wr_ptaken | input | 32 | Primary taken target |
| wr_pnot | input | 32 | Primary fall-through address |
| wr_tvalid | input | 1 | Second branch present on the taken side |
| wr_ttype | input | 2 | Type of the taken-side second branch |
| wr_nvalid | input | 1 | Second branch present on the not-taken side |
| wr_ntype | input | 2 | Type of the not-taken-side second branch |
| wr_tt | input | 32 | Taken then taken address |
| wr_tn | input | 32 | Taken then not-taken address |
| wr_nt | input | 32 | Not-taken then taken address |
| wr_nn | input | 32 | Not-taken then not-taken address |
| rs_valid | output | 1 | Result valid |
| rs_hit | output | 1 | Lookup hit a valid entry with matching tag |
| rs_count | output | 2 | Number of blocks vouched for (1 to 3) |
| rs_blk0 | output | 32 | Start of the first block (the fetch address) |
| rs_blk1 | output | 32 | Start of the second block |
| rs_blk2 | output | 32 | Start of the third block |

## Verification
The main sweep installs entries covering every primary type, every second-level type and every combination of primary and second-level valid flags, then looks each one up with all four predictor patterns. Varying the type against a fixed predictor pattern separates a block that obeys the predictor from one that honours the forced directions of unconditional and non-branch types. Varying the valid flags separates the one-, two- and three-block results and their fall-through fill. Directed cases cover a tag mismatch on an occupied index, a write and a lookup in the same cycle, and neighbouring indices.

// File: rtl/fetch_addr_cache.sv
module fetch_addr_cache #(
  parameter int AW = 32,
  parameter int IW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lk_valid,
  input  logic [AW-1:0] lk_addr,
  input  logic [1:0]    lk_dir,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_pvalid,
  input  logic [1:0]    wr_ptype,
  input  logic [AW-1:0] wr_ptaken,
  input  logic [AW-1:0] wr_pnot,
  input  logic          wr_tvalid,
  input  logic [1:0]    wr_ttype,
  input  logic          wr_nvalid,
  input  logic [1:0]    wr_ntype,
  input  logic [AW-1:0] wr_tt,
  input  logic [AW-1:0] wr_tn,
  input  logic [AW-1:0] wr_nt,
  input  logic [AW-1:0] wr_nn,
  output logic          rs_valid,
  output logic          rs_hit,
  output logic [1:0]    rs_count,
  output logic [AW-1:0] rs_blk0,
  output logic [AW-1:0] rs_blk1,
  output logic [AW-1:0] rs_blk2
);
  localparam int DEPTH = 1 << IW;
  localparam int TW    = AW - IW - 2;
  localparam logic [AW-1:0] STEP = AW'(4);

  typedef struct packed {
    logic [TW-1:0] tag;
    logic          pv;
    logic [1:0]    pty;
    logic          tv;
    logic [1:0]    tty;
    logic          nv;
    logic [1:0]    nty;
    logic [AW-1:0] pt, pn, tt, tn, nt, nn;
  } entry_t;

  entry_t           mem [DEPTH];
  logic [DEPTH-1:0] present;

  function automatic logic go_taken(input logic [1:0] ty, input logic pred);
    return (ty == 2'd1) | ((ty != 2'd3) & pred);
  endfunction

  wire [IW-1:0] wr_idx = wr_addr[IW+1:2];
  wire [IW-1:0] lk_idx = lk_addr[IW+1:2];
  entry_t e;
  assign e = mem[lk_idx];

  wire       hit   = present[lk_idx] && (e.tag == lk_addr[AW-1:IW+2]);
  wire       p_act = hit && e.pv;
  wire       t1    = go_taken(e.pty, lk_dir[0]);
  wire       s_v   = t1 ? e.tv  : e.nv;
  wire [1:0] s_ty  = t1 ? e.tty : e.nty;
  wire       s_act = p_act && s_v;
  wire       t2    = go_taken(s_ty, lk_dir[1]);

  wire [AW-1:0] b1 = p_act ? (t1 ? e.pt : e.pn) : lk_addr + STEP;
  wire [AW-1:0] b2_tree = t1 ? (t2 ? e.tt : e.tn) : (t2 ? e.nt : e.nn);
  wire [AW-1:0] b2 = s_act ? b2_tree : b1 + STEP;
  wire [1:0]    cnt = s_act ? 2'd3 : (p_act ? 2'd2 : 2'd1);

  always_ff @(posedge clk) begin
    if (wr_en)
      mem[wr_idx] <= '{tag: wr_addr[AW-1:IW+2], pv: wr_pvalid, pty: wr_ptype,
                       tv: wr_tvalid, tty: wr_ttype, nv: wr_nvalid, nty: wr_ntype,
                       pt: wr_ptaken, pn: wr_pnot, tt: wr_tt, tn: wr_tn,
                       nt: wr_nt, nn: wr_nn};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     present <= '0;
    else if (wr_en) present[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rs_valid <= 1'b0;
      rs_hit   <= 1'b0;
      rs_count <= 2'd0;
      rs_blk0  <= '0;
      rs_blk1  <= '0;
      rs_blk2  <= '0;
    end else begin
      rs_valid <= lk_valid;
      if (lk_valid) begin
        rs_hit   <= hit;
        rs_count <= cnt;
        rs_blk0  <= lk_addr;
        rs_blk1  <= b1;
        rs_blk2  <= b2;
      end
    end
  end
endmodule

// File: rtl/fetch_addr_cache_chk.sv
module fetch_addr_cache_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lk_valid,
  input logic [AW-1:0] lk_addr,
  input logic          rs_valid,
  input logic          rs_hit,
  input logic [1:0]    rs_count,
  input logic [AW-1:0] rs_blk0,
  input logic [AW-1:0] rs_blk1,
  input logic [AW-1:0] rs_blk2
);
  localparam logic [AW-1:0] STEP = AW'(4);

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> !rs_valid);

  assert_result_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> (rs_valid && rs_blk0 == $past(lk_addr)));

  assert_no_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rs_valid);

  assert_miss_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_hit) |-> (rs_count == 2'd1));

  assert_count_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid |-> (rs_count != 2'd0));

  assert_single_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_count == 2'd1) |-> (rs_blk1 == rs_blk0 + STEP && rs_blk2 == rs_blk1 + STEP));

  assert_double_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_count == 2'd2) |-> (rs_blk2 == rs_blk1 + STEP));
endmodule

bind fetch_addr_cache fetch_addr_cache_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
  .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_count(rs_count),
  .rs_blk0(rs_blk0), .rs_blk1(rs_blk1), .rs_blk2(rs_blk2)
);

// File: tb/test_fetch_addr_cache.sv
`timescale 1ns/1ps
module test_fetch_addr_cache;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_addr = '0;
  logic [1:0]  lk_dir = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_addr = '0;
  logic        wr_pvalid = 1'b0, wr_tvalid = 1'b0, wr_nvalid = 1'b0;
  logic [1:0]  wr_ptype = '0, wr_ttype = '0, wr_ntype = '0;
  logic [31:0] wr_ptaken = '0, wr_pnot = '0, wr_tt = '0, wr_tn = '0, wr_nt = '0, wr_nn = '0;
  logic        rs_valid, rs_hit;
  logic [1:0]  rs_count;
  logic [31:0] rs_blk0, rs_blk1, rs_blk2;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fetch_addr_cache i_fetch_addr_cache (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put_entry(input logic [31:0] fa, input logic pv, input logic [1:0] pty,
                           input logic tv, input logic [1:0] tty,
                           input logic nv, input logic [1:0] nty, input logic [31:0] base);
    wr_en = 1'b1; wr_addr = fa;
    wr_pvalid = pv; wr_ptype = pty; wr_tvalid = tv; wr_ttype = tty;
    wr_nvalid = nv; wr_ntype = nty;
    wr_ptaken = base + 32'h10; wr_pnot = base + 32'h20;
    wr_tt = base + 32'h30; wr_tn = base + 32'h40; wr_nt = base + 32'h50; wr_nn = base + 32'h60;
  endtask

  task automatic do_write(input logic [31:0] fa, input logic pv, input logic [1:0] pty,
                          input logic tv, input logic [1:0] tty,
                          input logic nv, input logic [1:0] nty, input logic [31:0] base);
    put_entry(fa, pv, pty, tv, tty, nv, nty, base);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_lookup(input logic [31:0] fa, input logic [1:0] d);
    lk_valid = 1'b1; lk_addr = fa; lk_dir = d;
    @(negedge clk);
    lk_valid = 1'b0; wr_en = 1'b0;
  endtask

  function automatic logic take(input logic [1:0] ty, input logic p);
    if (ty == 2'd1) return 1'b1;
    if (ty == 2'd3) return 1'b0;
    return p;
  endfunction

  task automatic expect_result(input string req, input logic [31:0] fa, input logic [1:0] d,
                               input logic hit, input logic pv, input logic [1:0] pty,
                               input logic tv, input logic [1:0] tty,
                               input logic nv, input logic [1:0] nty, input logic [31:0] base);
    logic t1, t2, sv;
    logic [1:0] sty, cnt;
    logic [31:0] b1, b2;
    cnt = 2'd1; b1 = fa + 32'd4; b2 = fa + 32'd8;
    if (hit && pv) begin
      t1 = take(pty, d[0]);
      b1 = base + (t1 ? 32'h10 : 32'h20);
      sv = t1 ? tv : nv;
      sty = t1 ? tty : nty;
      cnt = 2'd2; b2 = b1 + 32'd4;
      if (sv) begin
        t2 = take(sty, d[1]);
        cnt = 2'd3;
        b2 = base + (t1 ? (t2 ? 32'h30 : 32'h40) : (t2 ? 32'h50 : 32'h60));
      end
    end
    check({req, " valid"}, {31'd0, rs_valid}, 32'd1);
    check({req, " hit"},   {31'd0, rs_hit}, {31'd0, hit});
    check({req, " count"}, {30'd0, rs_count}, {30'd0, cnt});
    check({req, " blk0"},  rs_blk0, fa);
    check({req, " blk1"},  rs_blk1, b1);
    check({req, " blk2"},  rs_blk2, b2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset valid", {31'd0, rs_valid}, 32'd0);
    check("R1 reset count", {30'd0, rs_count}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int a = 0; a < 8; a++) begin
      logic [31:0] fa;
      fa = 32'h0012_3400 + 32'(a) * 32'h44;
      do_lookup(fa, a[1:0]);
      expect_result("R1 R3 cold miss", fa, a[1:0], 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 2'd0, 32'd0);
      check("R2 idle", {31'd0, rs_valid}, 32'd1);
      @(negedge clk);
      check("R2 no lookup", {31'd0, rs_valid}, 32'd0);
    end

    // R5 R6 R7 R8 R9 sweep
    for (int c = 0; c < 128; c++) begin
      logic [1:0] pty, sty;
      logic pv;
      logic [1:0] svm;
      logic [31:0] fa, base;
      pty = c[1:0]; sty = c[3:2]; pv = c[4]; svm = c[6:5];
      fa = {24'(c / 64 + 1), 6'(c % 64), 2'b00};
      base = 32'h4000_0000 + 32'(c) * 32'h100;
      do_write(fa, pv, pty, svm[0], sty, svm[1], 2'd3 - sty, base);
      for (int d = 0; d < 4; d++) begin
        do_lookup(fa, d[1:0]);
        expect_result("R5 R6 R7 R8 R9 sweep", fa, d[1:0], 1'b1, pv, pty, svm[0], sty,
                      svm[1], 2'd3 - sty, base);
      end
    end

    // R4: same index, different tag
    do_write(32'h0000_0A14, 1'b1, 2'd0, 1'b1, 2'd0, 1'b1, 2'd0, 32'h5000_0000);
    do_lookup(32'h0010_0A14, 2'b11);
    expect_result("R4 tag mismatch", 32'h0010_0A14, 2'b11, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 2'd0, 32'd0);
    do_lookup(32'h0000_0A14, 2'b11);
    expect_result("R4 tag match", 32'h0000_0A14, 2'b11, 1'b1, 1'b1, 2'd0, 1'b1, 2'd0, 1'b1, 2'd0, 32'h5000_0000);

    // R10: write and lookup in the same cycle
    put_entry(32'h0000_7714, 1'b1, 2'd0, 1'b1, 2'd0, 1'b1, 2'd0, 32'h6000_0000);
    do_lookup(32'h0000_7714, 2'b01);
    expect_result("R10 old content", 32'h0000_7714, 2'b01, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 2'd0, 32'd0);
    do_lookup(32'h0000_7714, 2'b01);
    expect_result("R10 new content", 32'h0000_7714, 2'b01, 1'b1, 1'b1, 2'd0, 1'b1, 2'd0, 1'b1, 2'd0, 32'h6000_0000);
    put_entry(32'h0000_7714, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 2'd0, 32'h7000_0000);
    do_lookup(32'h0000_7714, 2'b10);
    expect_result("R10 old before replace", 32'h0000_7714, 2'b10, 1'b1, 1'b1, 2'd0, 1'b1, 2'd0, 1'b1, 2'd0, 32'h6000_0000);
    do_lookup(32'h0000_7714, 2'b10);
    expect_result("R10 replaced", 32'h0000_7714, 2'b10, 1'b1, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 2'd0, 32'h7000_0000);

    // R11: neighbouring indices
    do_write(32'h0000_AA28, 1'b1, 2'd1, 1'b1, 2'd1, 1'b0, 2'd0, 32'h8000_0000);
    do_write(32'h0000_AA2C, 1'b1, 2'd3, 1'b0, 2'd0, 1'b1, 2'd3, 32'h9000_0000);
    do_lookup(32'h0000_AA28, 2'b00);
    expect_result("R11 first index", 32'h0000_AA28, 2'b00, 1'b1, 1'b1, 2'd1, 1'b1, 2'd1, 1'b0, 2'd0, 32'h8000_0000);
    do_lookup(32'h0000_AA2C, 2'b11);
    expect_result("R11 second index", 32'h0000_AA2C, 2'b11, 1'b1, 1'b1, 2'd3, 1'b0, 2'd0, 1'b1, 2'd3, 32'h9000_0000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule